// File: doc/BRIEF.md
# Sequential Instruction Line Prefetcher

This block sits between an instruction cache and the next memory level. On a cache miss it fetches the missing line and, right after it, the line at the following address. The missing line goes to the cache. The following line is kept in a single-line side buffer and does not enter the cache. Every later miss is compared against that buffer before any request goes out. If the buffer holds the missing line, the line is handed to the cache straight from the buffer, and a fetch of the line after it is started.

The cache offers one miss at a time as a line address. The block returns a line on a one-cycle fill strobe. Toward memory it drives a request port with a valid/ready handshake. Responses come back in request order, one per request, each carrying a whole line of 32 bytes by default.

Two situations need special handling:
- **Miss on an in-flight line.** If a miss names the line whose prefetch is still in flight, the block waits for that response and issues no second request.
- **Miss outside the sequence.** If a miss names a line that is neither buffered nor in flight, the buffer is emptied. The response of any older prefetch is thrown away when it arrives, and a new sequence begins at the missed line.

Top module: `istream_prefetch`

## Requirements
- R1: A miss on line A that finds neither a buffered nor an in-flight copy issues exactly two memory requests, first for A and then for A+1.
- R2: The response to the demand request for A appears on the fill port in the same cycle it arrives, with `fillAddr` = A and the returned line as `fillData`.
- R3: The response to a prefetch whose miss is not waiting on it is written into the side buffer and produces no fill. Issuing any request marks the buffer empty until that prefetch returns.
- R4: A miss on the line held in a valid buffer produces a fill exactly one cycle after the accepting edge, carrying the buffered line, and no demand request.
- R5: After such a buffer hit, the next memory request is a prefetch of the missed line plus one.
- R6: A miss on the line whose prefetch is still in flight issues no request for that line. It is filled in the cycle the prefetch response arrives and is followed by a prefetch of that line plus one.
- R7: A miss outside the current sequence while a prefetch is in flight causes that prefetch's response to be discarded. Only the newly missed line is filled, with its own data.
- R8: While `memReqReady` is low, `memReqValid` stays high and `memReqAddr` stays unchanged.
- R9: `missReady` is high only when the block is idle and no response is being presented. One miss is accepted at a time, and each accepted miss yields exactly one fill.
- R10: After reset, `missReady` is high, no request or fill is driven, the buffer is empty, and no prefetch is pending, so the first miss goes to memory even at line 0.
- R11: Line addresses wrap: a miss on the all-ones line prefetches line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| missValid | input | 1 | Cache presents a miss |
| missReady | output | 1 | Block accepts the miss this cycle |
| missAddr | input | ADDR_W | Missed line address |
| fillValid | output | 1 | One-cycle line delivery to the cache |
| fillAddr | output | ADDR_W | Line address being delivered |
| fillData | output | LINE_W | Line contents being delivered |
| memReqValid | output | 1 | Request to next memory level |
| memReqReady | input | 1 | Next level takes the request |
| memReqAddr | output | ADDR_W | Requested line address |
| memRspValid | input | 1 | In-order response present (always consumed) |
| memRspData | input | LINE_W | Response line contents |

## Verification
A buffer hit fills one cycle after the accepting edge, and the prefetch request of the next line follows one cycle later. A fill sourced from memory is combinational with the response, so it appears in the same cycle the response is presented.

The bench drives all inputs and samples all outputs on the falling clock edge. It records the cycle at which each fill is seen and compares that cycle against the acceptance cycle only for buffer hits. Memory-sourced cases are instead judged by request order, request count, fill count and fill data after the model's queue has drained.

The model's response latency is swept, and responses are stalled to create the in-flight and stale-prefetch cases.

// File: rtl/istream_pf_pkg.sv
package istream_pf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL_BUF,
    ST_WAIT_PF,
    ST_REQ_DEM,
    ST_REQ_PF,
    ST_WAIT_DEM
  } pfState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;     // capture missed line address
    logic flushBuf;     // drop buffer, mark in-flight prefetch stale
    logic pfIssued;     // prefetch request accepted by memory
    logic pfLand;       // live prefetch response present
    logic pfToBuf;      // that response is parked in the buffer
    logic dropRsp;      // stale response consumed
    logic reqNext;      // request address is line + 1
    logic fillFromBuf;  // fill data sourced from buffer
  } pfStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic bufHit;
    logic flightHit;
    logic pfPending;
    logic pfStale;
  } pfStatus_t;

endpackage

// File: rtl/istream_pf_datapath.sv
module istream_pf_datapath
  import istream_pf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfStrobe_t         strobe,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [LINE_W-1:0] memRspData,
  output pfStatus_t         status,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [LINE_W-1:0] fillData,
  output logic              bufValid,
  output logic [ADDR_W-1:0] bufTag,
  output logic [LINE_W-1:0] bufData,
  output logic              pfPending
);

  logic [ADDR_W-1:0] reqAddr;
  logic [ADDR_W-1:0] nextLine;
  logic              pfStale;

  assign nextLine = reqAddr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr <= '0;
    end else if (strobe.latchReq) begin
      reqAddr <= missAddr;
    end
  end

  // buffer tag / valid / pending tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid  <= 1'b0;
      bufTag    <= '0;
      pfPending <= 1'b0;
      pfStale   <= 1'b0;
    end else begin
      if (strobe.dropRsp) begin
        pfStale <= 1'b0;
      end
      if (strobe.pfLand) begin
        pfPending <= 1'b0;
        if (strobe.pfToBuf) begin
          bufValid <= 1'b1;
        end
      end
      if (strobe.flushBuf) begin
        bufValid  <= 1'b0;
        pfPending <= 1'b0;
        pfStale   <= pfStale | pfPending;
      end
      if (strobe.pfIssued) begin
        bufTag    <= nextLine;
        bufValid  <= 1'b0;
        pfPending <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData <= '0;
    end else if (strobe.pfLand && strobe.pfToBuf) begin
      bufData <= memRspData;
    end
  end

  assign status.bufHit    = bufValid && (bufTag == missAddr);
  assign status.flightHit = pfPending && (bufTag == missAddr);
  assign status.pfPending = pfPending;
  assign status.pfStale   = pfStale;

  assign memReqAddr = strobe.reqNext ? nextLine : reqAddr;
  assign fillAddr   = reqAddr;
  assign fillData   = strobe.fillFromBuf ? bufData : memRspData;

endmodule

// File: rtl/istream_pf_ctrl.sv
module istream_pf_ctrl
  import istream_pf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      missValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  pfStatus_t status,
  output pfStrobe_t strobe,
  output logic      missReady,
  output logic      memReqValid,
  output logic      fillValid
);

  pfState_e state;
  pfState_e nextState;
  logic     demPend;
  logic     accept;
  logic     rspDrop;
  logic     rspDem;
  logic     rspPf;

  assign missReady = (state == ST_IDLE) && !memRspValid;
  assign accept    = missValid && missReady;

  // in-order response routing: stale first, then demand, then prefetch
  assign rspDrop = memRspValid && status.pfStale;
  assign rspDem  = memRspValid && !status.pfStale && demPend;
  assign rspPf   = memRspValid && !status.pfStale && !demPend && status.pfPending;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (status.bufHit)         nextState = ST_FILL_BUF;
          else if (status.flightHit) nextState = ST_WAIT_PF;
          else                       nextState = ST_REQ_DEM;
        end
      end
      ST_FILL_BUF: nextState = ST_REQ_PF;
      ST_WAIT_PF:  if (rspPf) nextState = ST_REQ_PF;
      ST_REQ_DEM:  if (memReqReady) nextState = ST_REQ_PF;
      ST_REQ_PF: begin
        if (memReqReady) nextState = (demPend && !rspDem) ? ST_WAIT_DEM : ST_IDLE;
      end
      ST_WAIT_DEM: if (rspDem) nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      demPend <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_REQ_DEM && memReqReady) begin
        demPend <= 1'b1;
      end else if (rspDem) begin
        demPend <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.latchReq    = accept;
    strobe.flushBuf    = accept && !status.bufHit && !status.flightHit;
    strobe.pfIssued    = (state == ST_REQ_PF) && memReqReady;
    strobe.pfLand      = rspPf;
    strobe.pfToBuf     = rspPf && (state != ST_WAIT_PF);
    strobe.dropRsp     = rspDrop;
    strobe.reqNext     = (state == ST_REQ_PF);
    strobe.fillFromBuf = (state == ST_FILL_BUF);
  end

  assign memReqValid = (state == ST_REQ_DEM) || (state == ST_REQ_PF);
  assign fillValid   = (state == ST_FILL_BUF) || rspDem || ((state == ST_WAIT_PF) && rspPf);

endmodule

// File: rtl/istream_prefetch.sv
module istream_prefetch
  import istream_pf_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    missValid,
  output logic                    missReady,
  input  logic [ADDR_W-1:0]       missAddr,
  output logic                    fillValid,
  output logic [ADDR_W-1:0]       fillAddr,
  output logic [LINE_BYTES*8-1:0] fillData,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memRspValid,
  input  logic [LINE_BYTES*8-1:0] memRspData
);

  localparam int LINE_W = LINE_BYTES * 8;

  pfStrobe_t         strobe;
  pfStatus_t         status;
  logic              bufValid;
  logic [ADDR_W-1:0] bufTag;
  logic [LINE_W-1:0] bufData;
  logic              pfPending;

  istream_pf_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .status      (status),
    .strobe      (strobe),
    .missReady   (missReady),
    .memReqValid (memReqValid),
    .fillValid   (fillValid)
  );

  istream_pf_datapath #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .missAddr   (missAddr),
    .memRspData (memRspData),
    .status     (status),
    .memReqAddr (memReqAddr),
    .fillAddr   (fillAddr),
    .fillData   (fillData),
    .bufValid   (bufValid),
    .bufTag     (bufTag),
    .bufData    (bufData),
    .pfPending  (pfPending)
  );

endmodule

// File: rtl/istream_prefetch_chk.sv
module istream_prefetch_chk #(
  parameter int ADDR_W = 12,
  parameter int LINE_W = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              missReady,
  input logic [ADDR_W-1:0] missAddr,
  input logic              fillValid,
  input logic [ADDR_W-1:0] fillAddr,
  input logic [LINE_W-1:0] fillData,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              bufValid,
  input logic [ADDR_W-1:0] bufTag,
  input logic [LINE_W-1:0] bufData,
  input logic              pfPending
);

  p_reset_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!bufValid && !pfPending && missReady));

  p_bufhit_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady && bufValid && bufTag == missAddr) |=>
      (fillValid && fillAddr == $past(missAddr) && fillData == $past(bufData) && !memReqValid));

  p_issue_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !bufValid);

  p_no_dup_r6: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady && pfPending && bufTag == missAddr) |=> !memReqValid);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> !missReady);

  p_single_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> !fillValid);

endmodule

bind istream_prefetch istream_prefetch_chk #(
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .missValid   (missValid),
  .missReady   (missReady),
  .missAddr    (missAddr),
  .fillValid   (fillValid),
  .fillAddr    (fillAddr),
  .fillData    (fillData),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .bufValid    (bufValid),
  .bufTag      (bufTag),
  .bufData     (bufData),
  .pfPending   (pfPending)
);

// File: tb/istream_prefetch_tb.sv
module istream_prefetch_tb;
  localparam int AW = 8;
  localparam int LB = 32;
  localparam int LW = LB * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          missValid = 1'b0;
  logic          missReady;
  logic [AW-1:0] missAddr = '0;
  logic          fillValid;
  logic [AW-1:0] fillAddr;
  logic [LW-1:0] fillData;
  logic          memReqValid;
  logic          memReqReady = 1'b1;
  logic [AW-1:0] memReqAddr;
  logic          memRspValid = 1'b0;
  logic [LW-1:0] memRspData = '0;

  always #2 clk = ~clk;

  istream_prefetch #(.ADDR_W(AW), .LINE_BYTES(LB)) u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missReady(missReady),
    .missAddr(missAddr), .fillValid(fillValid), .fillAddr(fillAddr),
    .fillData(fillData), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lat = 4;
  int fillCnt = 0;
  bit stall = 1'b0;
  bit done = 1'b0;
  logic [AW-1:0] qA[$];
  int            qT[$];
  logic [AW-1:0] reqLog[$];

  function automatic logic [LW-1:0] lineData(input logic [AW-1:0] a);
    logic [LW-1:0] v;
    for (int j = 0; j < LW / 32; j++) begin
      v[j*32 +: 32] = (32'(a) * 32'h9E3779B1) ^ (32'(j) << 24) ^ 32'h5A0000C3;
    end
    return v;
  endfunction

  // in-order memory model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fillValid) fillCnt <= fillCnt + 1;
    if (memRspValid) begin
      void'(qA.pop_front());
      void'(qT.pop_front());
    end
    if (memReqValid && memReqReady) begin
      qA.push_back(memReqAddr);
      qT.push_back(cyc + lat);
      reqLog.push_back(memReqAddr);
    end
    if (qA.size() > 0 && !stall && qT[0] <= cyc) begin
      memRspValid <= 1'b1;
      memRspData  <= lineData(qA[0]);
    end else begin
      memRspValid <= 1'b0;
    end
  end

  task automatic chkInt(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkLine(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issueMiss(input logic [AW-1:0] a, output int acc);
    @(negedge clk);
    missValid = 1'b1;
    missAddr  = a;
    while (!missReady) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    missValid = 1'b0;
    chkInt(!missReady, "R9 busy after accept", missReady, 0);
  endtask

  task automatic waitFill(output int t, output logic [AW-1:0] fa, output logic [LW-1:0] fd);
    int n = 0;
    while (!fillValid && n < 200) begin
      @(negedge clk);
      n++;
    end
    t  = cyc;
    fa = fillAddr;
    fd = fillData;
  endtask

  task automatic waitDrain();
    int n = 0;
    while ((qA.size() != 0 || memRspValid || !missReady) && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic coldMiss(input logic [AW-1:0] a, input string tag);
    int n0, f0, acc, t;
    logic [AW-1:0] fa;
    logic [LW-1:0] fd;
    n0 = reqLog.size();
    f0 = fillCnt;
    issueMiss(a, acc);
    waitFill(t, fa, fd);
    chkInt(fa == a, {tag, " R2 fill addr"}, fa, a);
    chkLine({tag, " R2 fill data"}, fd, lineData(a));
    waitDrain();
    chkInt(reqLog.size() - n0 == 2, {tag, " R1 request count"}, reqLog.size() - n0, 2);
    if (reqLog.size() - n0 == 2) begin
      chkInt(reqLog[n0] == a, {tag, " R1 demand first"}, reqLog[n0], a);
      chkInt(reqLog[n0+1] == AW'(a + 1), {tag, " R1 R11 prefetch second"}, reqLog[n0+1], AW'(a + 1));
    end
    chkInt(fillCnt - f0 == 1, {tag, " R3 prefetch not filled"}, fillCnt - f0, 1);
  endtask

  task automatic bufHit(input logic [AW-1:0] a, input string tag);
    int n0, f0, acc, t;
    logic [AW-1:0] fa;
    logic [LW-1:0] fd;
    n0 = reqLog.size();
    f0 = fillCnt;
    issueMiss(a, acc);
    waitFill(t, fa, fd);
    chkInt(t == acc + 1, {tag, " R4 fill one cycle after accept"}, t - acc, 1);
    chkLine({tag, " R4 buffered data"}, fd, lineData(a));
    waitDrain();
    chkInt(reqLog.size() - n0 == 1, {tag, " R5 one prefetch only"}, reqLog.size() - n0, 1);
    if (reqLog.size() - n0 == 1)
      chkInt(reqLog[n0] == AW'(a + 1), {tag, " R5 prefetch line+1"}, reqLog[n0], AW'(a + 1));
    chkInt(fillCnt - f0 == 1, {tag, " R9 one fill"}, fillCnt - f0, 1);
  endtask

  initial begin
    int acc, t, n0, f0;
    logic [AW-1:0] fa;
    logic [LW-1:0] fd;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkInt(missReady, "R10 ready after reset", missReady, 1);
    chkInt(!memReqValid, "R10 no request after reset", memReqValid, 0);
    chkInt(!fillValid, "R10 no fill after reset", fillValid, 0);

    coldMiss(8'h00, "R10 first miss line0");
    bufHit(8'h01, "hit1");

    // sequential sweep with varied latency
    for (int l = 1; l <= 6; l++) begin
      lat = l;
      coldMiss(AW'(8'h20 + l * 16), "sweep cold");
      for (int k = 1; k <= 4; k++) bufHit(AW'(8'h20 + l * 16 + k), "sweep hit");
    end
    lat = 4;

    // wrap
    coldMiss(8'hFF, "R11 wrap");
    bufHit(8'h00, "R11 wrap hit");

    // R6: miss on in-flight prefetch
    n0 = reqLog.size();
    issueMiss(8'h90, acc);
    waitFill(t, fa, fd);
    stall = 1'b1;
    chkLine("R6 setup demand data", fd, lineData(8'h90));
    while (!missReady) @(negedge clk);
    f0 = fillCnt;
    issueMiss(8'h91, acc);
    repeat (6) @(negedge clk);
    chkInt(fillCnt == f0, "R6 waits for prefetch", fillCnt - f0, 0);
    chkInt(reqLog.size() - n0 == 2, "R6 no duplicate request", reqLog.size() - n0, 2);
    @(negedge clk);
    stall = 1'b0;
    waitFill(t, fa, fd);
    chkInt(fa == 8'h91, "R6 fill addr", fa, 8'h91);
    chkLine("R6 fill data", fd, lineData(8'h91));
    waitDrain();
    chkInt(reqLog.size() - n0 == 3, "R6 next prefetch count", reqLog.size() - n0, 3);
    if (reqLog.size() - n0 == 3)
      chkInt(reqLog[n0+2] == 8'h92, "R6 next prefetch addr", reqLog[n0+2], 8'h92);
    bufHit(8'h92, "R6 chain hit");

    // R7: unrelated miss while a prefetch is in flight
    issueMiss(8'h40, acc);
    waitFill(t, fa, fd);
    stall = 1'b1;
    while (!missReady) @(negedge clk);
    n0 = reqLog.size();
    f0 = fillCnt;
    issueMiss(8'hC5, acc);
    repeat (4) @(negedge clk);
    stall = 1'b0;
    waitFill(t, fa, fd);
    chkInt(fa == 8'hC5, "R7 fill addr", fa, 8'hC5);
    chkLine("R7 fill data not stale", fd, lineData(8'hC5));
    waitDrain();
    chkInt(fillCnt - f0 == 1, "R7 stale discarded", fillCnt - f0, 1);
    chkInt(reqLog.size() - n0 == 2, "R7 new sequence requests", reqLog.size() - n0, 2);
    if (reqLog.size() - n0 == 2) begin
      chkInt(reqLog[n0] == 8'hC5, "R7 demand addr", reqLog[n0], 8'hC5);
      chkInt(reqLog[n0+1] == 8'hC6, "R7 prefetch addr", reqLog[n0+1], 8'hC6);
    end
    bufHit(8'hC6, "R7 buffer refilled");
    coldMiss(8'h41, "R7 old line flushed");

    // R8: backpressure
    @(negedge clk);
    memReqReady = 1'b0;
    n0 = reqLog.size();
    issueMiss(8'h70, acc);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chkInt(memReqValid && memReqAddr == 8'h70, "R8 request held", memReqAddr, 8'h70);
    end
    memReqReady = 1'b1;
    waitFill(t, fa, fd);
    chkLine("R8 fill data", fd, lineData(8'h70));
    waitDrain();
    if (reqLog.size() - n0 == 2)
      chkInt(reqLog[n0+1] == 8'h71, "R8 R1 order kept", reqLog[n0+1], 8'h71);
    else
      chkInt(0, "R8 request count", reqLog.size() - n0, 2);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule